// File: doc/BRIEF.md
# Switch Register Access Bridge

This block gives a host processor a window into the paged internal registers of an Ethernet switch core. The host sees a handful of 32-bit registers: a control word with an access request and a read-only grant, a command word, two write data words and two read data words. The far side is a plain switch register bus. It carries an 8-bit page, an 8-bit register number, a write flag, 64 bits of write data and a one-cycle strobe. It returns 64 bits of read data and a done pulse.

Software first raises the request and waits for the grant. It loads the two write data words when it is writing. It then writes one command word that holds the page, the register, the write flag and a go bit. The go bit reads back as busy until the switch answers. A read result is then available in the two read data words. Clearing the request gives up the bridge. A reset bit in the command word returns the data path to its idle state without touching the request.

Top module: `swreg_bridge`

## Requirements
- R1: After reset every host register reads zero, except bit 6 of the control word, which follows `initDone`. `swStrobe` is low.
- R2: With `agentBusy` low, the grant (control bit 4) rises exactly GRANT_DELAY cycles after the request (control bit 3) is set. A cycle with `agentBusy` high before the grant restarts that count.
- R3: The grant reads zero in the first cycle after the request has been cleared.
- R4: A command write (offset 0x2C, bit 0 = go, bit 2 = 0) made while the grant is held and no access is busy has these effects. One cycle later `swStrobe` pulses high for exactly one cycle. In that cycle `swPage` carries command bits 31:24, `swReg` carries bits 23:16, `swWrite` carries bit 1 and `swWdata` carries {high word 0x30, low word 0x34}. Command bit 0 then reads 1.
- R5: Command bit 0 reads 0 in the cycle after `swDone` is seen during a busy access. The page, register and write fields keep their values.
- R6: When a read completes, `swRdata` bits 63:32 are captured into offset 0x38 and bits 31:0 into offset 0x3C. When a write completes, both words stay unchanged.
- R7: A command written without the grant, or while an access is busy, is ignored. This includes a command written in the same cycle as `swDone`. No strobe is produced and the command readback stays unchanged.
- R8: In the control word at 0x40, bit 3 is the host request (read/write), bit 4 is the grant (read-only) and bit 6 mirrors `initDone` (read-only). All other bits read zero.
- R9: A command write with bit 2 set clears both write words, both read words, the command fields and busy. It launches nothing, whatever bit 0 holds. The request and grant are kept.
- R10: Writes to the write data words at 0x30 or 0x34 are ignored while an access is busy, so `swWdata` stays stable.
- R11: Reads from an offset that maps to no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access valid |
| hostWrite | input | 1 | Host access is a write |
| hostAddr | input | ADDR_W | Host byte offset |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data (combinational from hostAddr) |
| agentBusy | input | 1 | Another agent holds the switch bus and blocks the grant |
| initDone | input | 1 | The switch has finished initialisation |
| swStrobe | output | 1 | One-cycle access strobe to the switch |
| swWrite | output | 1 | Access is a write |
| swPage | output | 8 | Register page |
| swReg | output | 8 | Register number within the page |
| swWdata | output | 64 | Write data to the switch |
| swRdata | input | 64 | Read data from the switch |
| swDone | input | 1 | Access complete |

## Verification
Completion of an access and a new command from the host can fall on the same clock edge. The busy flag is evaluated before that edge, so the new command must be rejected even though the bridge becomes idle at that same edge. The bench provokes this by taking over the switch side, raising `swDone` in the very cycle that it writes a fresh command. It then checks four things: the command readback still shows the old page and register with go clear, the read words hold the returned data, and no further strobe ever appears. The switch responder otherwise answers with a random latency of 1 to 8 cycles.

// File: rtl/swreg_bridge_pkg.sv
package swreg_bridge_pkg;
  localparam int PAGE_W = 8;
  localparam int DATA_W = 64;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_CMD  = 8'h2C;
  localparam logic [7:0] OFS_WDH  = 8'h30;
  localparam logic [7:0] OFS_WDL  = 8'h34;
  localparam logic [7:0] OFS_RDH  = 8'h38;
  localparam logic [7:0] OFS_RDL  = 8'h3C;
  localparam logic [7:0] OFS_CTRL = 8'h40;

  localparam int BIT_GO  = 0;
  localparam int BIT_WR  = 1;
  localparam int BIT_RST = 2;
  localparam int BIT_REQ = 3;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic launch;
    logic complete;
    logic clearAll;
  } dpStrobe_t;
endpackage

// File: rtl/swreg_ctrl.sv
module swreg_ctrl
  import swreg_bridge_pkg::*;
#(
  parameter int GRANT_DELAY = 3,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostGoBit,
  input  logic              hostRstBit,
  input  logic              hostReqBit,
  input  logic              agentBusy,
  input  logic              swDone,
  output dpStrobe_t         stb,
  output logic              busy,
  output logic              reqOut,
  output logic              grantOut,
  output logic              swStrobe
);
  localparam int CNT_W = (GRANT_DELAY < 2) ? 1 : $clog2(GRANT_DELAY + 1);

  logic             req;
  logic             grantQ;
  logic [CNT_W-1:0] cnt;
  logic             hostWr;
  logic             hitCmd;

  assign hostWr   = hostValid & hostWrite;
  assign hitCmd   = hostWr && (hostAddr == ADDR_W'(OFS_CMD));
  assign grantOut = grantQ & req;
  assign reqOut   = req;

  always_comb begin
    stb.loadHi   = hostWr && (hostAddr == ADDR_W'(OFS_WDH)) && !busy;
    stb.loadLo   = hostWr && (hostAddr == ADDR_W'(OFS_WDL)) && !busy;
    stb.clearAll = hitCmd && hostRstBit;
    stb.launch   = hitCmd && !hostRstBit && hostGoBit && grantOut && !busy;
    stb.complete = busy && swDone && !stb.clearAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      swStrobe <= 1'b0;
      req      <= 1'b0;
    end else begin
      swStrobe <= stb.launch;
      if (stb.clearAll)     busy <= 1'b0;
      else if (stb.launch)  busy <= 1'b1;
      else if (stb.complete) busy <= 1'b0;
      if (hostWr && (hostAddr == ADDR_W'(OFS_CTRL))) req <= hostReqBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !req) begin
      grantQ <= 1'b0;
      cnt    <= '0;
    end else if (!grantQ) begin
      if (agentBusy)                         cnt    <= '0;
      else if (cnt == CNT_W'(GRANT_DELAY-1)) grantQ <= 1'b1;
      else                                   cnt    <= cnt + CNT_W'(1);
    end
  end

  // R4: the strobe is a single-cycle pulse and marks a busy access
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    swStrobe |=> !swStrobe);
  a_r4_strobe_busy: assert property (@(posedge clk) disable iff (!rstN)
    swStrobe |-> busy);
  // R7: no launch without a grant in the cycle before
  a_r7_strobe_grant: assert property (@(posedge clk) disable iff (!rstN)
    swStrobe |-> $past(grantOut));
  // R5: completion frees the bridge
  a_r5_done_frees: assert property (@(posedge clk) disable iff (!rstN)
    (busy && swDone) |=> !busy);
  // R2: a grant only rises with the request up and no other agent
  a_r2_grant_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantQ) |-> ($past(req) && !$past(agentBusy)));
  // R3: the internal grant follows a dropped request
  a_r3_grant_drop: assert property (@(posedge clk) disable iff (!rstN)
    !req |=> !grantQ);
endmodule

// File: rtl/swreg_datapath.sv
module swreg_datapath
  import swreg_bridge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic              busy,
  input  logic              req,
  input  logic              grant,
  input  logic              initDone,
  input  logic [DATA_W-1:0] swRdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic [PAGE_W-1:0] swPage,
  output logic [PAGE_W-1:0] swReg,
  output logic              swWrite,
  output logic [DATA_W-1:0] swWdata
);
  logic [WORD_W-1:0] wdHi, wdLo, rdHi, rdLo;
  logic [PAGE_W-1:0] cmdPage, cmdReg;
  logic              cmdWrite;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAll) begin
      wdHi     <= '0;
      wdLo     <= '0;
      rdHi     <= '0;
      rdLo     <= '0;
      cmdPage  <= '0;
      cmdReg   <= '0;
      cmdWrite <= 1'b0;
    end else begin
      if (stb.loadHi) wdHi <= hostWdata;
      if (stb.loadLo) wdLo <= hostWdata;
      if (stb.launch) begin
        cmdPage  <= hostWdata[31:24];
        cmdReg   <= hostWdata[23:16];
        cmdWrite <= hostWdata[BIT_WR];
      end
      if (stb.complete && !cmdWrite) {rdHi, rdLo} <= swRdata;
    end
  end

  assign swPage  = cmdPage;
  assign swReg   = cmdReg;
  assign swWrite = cmdWrite;
  assign swWdata = {wdHi, wdLo};

  always_comb begin
    case (hostAddr)
      ADDR_W'(OFS_CMD):  hostRdata = {cmdPage, cmdReg, 14'b0, cmdWrite, busy};
      ADDR_W'(OFS_WDH):  hostRdata = wdHi;
      ADDR_W'(OFS_WDL):  hostRdata = wdLo;
      ADDR_W'(OFS_RDH):  hostRdata = rdHi;
      ADDR_W'(OFS_RDL):  hostRdata = rdLo;
      ADDR_W'(OFS_CTRL): hostRdata = {25'b0, initDone, 1'b0, grant, req, 3'b0};
      default:           hostRdata = '0;
    endcase
  end

  // R6: read words change only on a read completion or a bridge reset
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(stb.complete && !cmdWrite) && !stb.clearAll) |=> $stable({rdHi, rdLo}));
  // R10: write words are frozen during a busy access
  a_r10_wd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.clearAll) |=> $stable(swWdata));
  // R7: command fields are frozen during a busy access
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.clearAll) |=> $stable({cmdPage, cmdReg, cmdWrite}));
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
  import swreg_bridge_pkg::*;
#(
  parameter int GRANT_DELAY = 3,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  input  logic              agentBusy,
  input  logic              initDone,
  output logic              swStrobe,
  output logic              swWrite,
  output logic [7:0]        swPage,
  output logic [7:0]        swReg,
  output logic [63:0]       swWdata,
  input  logic [63:0]       swRdata,
  input  logic              swDone
);
  dpStrobe_t stb;
  logic      busy, req, grant;

  swreg_ctrl #(.GRANT_DELAY(GRANT_DELAY), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostGoBit(hostWdata[BIT_GO]),
    .hostRstBit(hostWdata[BIT_RST]), .hostReqBit(hostWdata[BIT_REQ]),
    .agentBusy(agentBusy), .swDone(swDone), .stb(stb), .busy(busy),
    .reqOut(req), .grantOut(grant), .swStrobe(swStrobe)
  );

  swreg_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .busy(busy), .req(req), .grant(grant),
    .initDone(initDone), .swRdata(swRdata), .hostRdata(hostRdata),
    .swPage(swPage), .swReg(swReg), .swWrite(swWrite), .swWdata(swWdata)
  );
endmodule

// File: tb/sim_swreg_bridge.sv
module sim_swreg_bridge;
  localparam int GD = 3;
  localparam logic [7:0] A_CMD = 8'h2C, A_WDH = 8'h30, A_WDL = 8'h34;
  localparam logic [7:0] A_RDH = 8'h38, A_RDL = 8'h3C, A_CTRL = 8'h40;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, hostValid, hostWrite, agentBusy, initDone;
  logic [7:0]  hostAddr;
  logic [31:0] hostWdata, hostRdata;
  logic        swStrobe, swWrite, swDone;
  logic [7:0]  swPage, swReg;
  logic [63:0] swWdata, swRdata;

  swreg_bridge #(.GRANT_DELAY(GD), .ADDR_W(8)) u0 (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .agentBusy(agentBusy), .initDone(initDone), .swStrobe(swStrobe),
    .swWrite(swWrite), .swPage(swPage), .swReg(swReg), .swWdata(swWdata),
    .swRdata(swRdata), .swDone(swDone)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // switch model
  logic [63:0] mem [64];
  logic [63:0] shadow [64];
  logic        manual;
  int          strobeCount;

  function automatic logic [63:0] seedVal(int i);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0303_0505_0707);
  endfunction

  initial begin
    int pend, li;
    logic lw;
    logic [63:0] lwd;
    pend = 0; li = 0; lw = 0; lwd = '0;
    swDone = 1'b0; swRdata = '0; strobeCount = 0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = seedVal(i);
      shadow[i] = seedVal(i);
    end
    forever begin
      @(negedge clk);
      if (!manual) begin
        if (swDone) swDone = 1'b0;
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            swDone = 1'b1;
            if (lw) mem[li] = lwd;
            else swRdata = mem[li];
          end
        end
      end
      if (swStrobe) begin
        strobeCount++;
        li  = {swPage[1:0], swReg[3:0]};
        lw  = swWrite;
        lwd = swWdata;
        if (!manual) pend = $urandom_range(1, 8);
      end
    end
  end

  task automatic hostWrNow(logic [7:0] a, logic [31:0] d);
    hostValid = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostValid = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic hostWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hostWrNow(a, d);
  endtask

  task automatic hostRd(logic [7:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int k = 0; k < 40; k++) begin
      hostRd(A_CMD, v);
      if (!v[0]) return;
      @(negedge clk);
    end
    chk("R5 busy never cleared", 1, 0);
  endtask

  task automatic access(logic [7:0] p, logic [7:0] r, logic wr);
    hostWr(A_CMD, {p, r, 14'b0, wr, 1'b1});
    waitIdle();
  endtask

  task automatic countGrant(output int n);
    logic [31:0] v;
    n = 0;
    hostRd(A_CTRL, v);
    while (!v[4] && n < 50) begin
      @(negedge clk);
      n++;
      hostRd(A_CTRL, v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v, hi, lo;
    int n, sc;
    rstN = 1'b0; hostValid = 0; hostWrite = 0; hostAddr = '0; hostWdata = '0;
    agentBusy = 0; initDone = 0; manual = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    hostRd(A_CMD, v);  chk("R1 cmd", v, 0);
    hostRd(A_WDH, v);  chk("R1 wdh", v, 0);
    hostRd(A_WDL, v);  chk("R1 wdl", v, 0);
    hostRd(A_RDH, v);  chk("R1 rdh", v, 0);
    hostRd(A_RDL, v);  chk("R1 rdl", v, 0);
    hostRd(A_CTRL, v); chk("R1 ctrl", v, 0);
    chk("R1 strobe", swStrobe, 0);
    initDone = 1;
    hostRd(A_CTRL, v); chk("R8 init done", v, 32'h40);
    hostRd(8'h10, v);  chk("R11 unmapped", v, 0);
    hostRd(8'h44, v);  chk("R11 unmapped 44", v, 0);
    hostWr(A_CTRL, 32'h0000_0050);
    hostRd(A_CTRL, v); chk("R8 read-only bits", v, 32'h40);

    // R7 command without grant
    hostWr(A_CMD, 32'h0102_0001);
    repeat (10) @(negedge clk);
    chk("R7 no strobe without grant", strobeCount, 0);
    hostRd(A_CMD, v); chk("R7 cmd unchanged without grant", v, 0);

    // R2 grant blocked by another agent, then counted from its release
    agentBusy = 1;
    hostWr(A_CTRL, 32'h8);
    repeat (10) @(negedge clk);
    hostRd(A_CTRL, v); chk("R2 grant held off by agent", v, 32'h48);
    agentBusy = 0;
    countGrant(n); chk("R2 delay after agent release", n, GD);
    hostWr(A_CTRL, 32'h0);
    hostRd(A_CTRL, v); chk("R3 grant dropped", v, 32'h40);
    hostWr(A_CTRL, 32'h8);
    countGrant(n); chk("R2 plain grant delay", n, GD);

    // R4/R6 sweep: writes then reads over 4 pages x 16 registers
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 16; r++) begin
        logic [63:0] d;
        d = {8'(p), 8'(r), 16'hA5C3, 8'(p * 16 + r), 24'h5A_3C_00} ^ 64'(r * 977);
        hostWr(A_WDH, d[63:32]);
        hostWr(A_WDL, d[31:0]);
        sc = strobeCount;
        access(8'(p), 8'(r), 1'b1);
        chk("R4 one strobe per write", strobeCount, sc + 1);
        shadow[p * 16 + r] = d;
      end
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 16; r++) begin
        access(8'(p), 8'(r), 1'b0);
        repeat (1) @(negedge clk);
        hostRd(A_RDH, hi); hostRd(A_RDL, lo);
        chk("R6 read capture", {hi, lo}, shadow[p * 16 + r]);
      end
    // R6 write completion leaves read words
    hostRd(A_RDH, hi); hostRd(A_RDL, lo);
    hostWr(A_WDL, 32'hDEAD_BEEF);
    access(8'h00, 8'h01, 1'b1);
    hostRd(A_RDH, v); chk("R6 write keeps rdh", v, hi);
    hostRd(A_RDL, v); chk("R6 write keeps rdl", v, lo);

    // manual switch side: launch fields, busy, collision
    manual = 1;
    repeat (12) @(negedge clk);
    swDone = 0;
    sc = strobeCount;
    hostWr(A_WDH, 32'h1111_2222);
    hostWr(A_WDL, 32'h3333_4444);
    hostWr(A_CMD, 32'h0509_0001);
    chk("R4 strobe", swStrobe, 1);
    chk("R4 page", swPage, 8'h05);
    chk("R4 reg", swReg, 8'h09);
    chk("R4 write flag", swWrite, 0);
    chk("R4 wdata", swWdata, 64'h1111_2222_3333_4444);
    hostRd(A_CMD, v); chk("R4 busy readback", v, 32'h0509_0001);
    @(negedge clk);
    chk("R4 strobe single", swStrobe, 0);
    hostWr(A_WDL, 32'h7777_7777);
    hostRd(A_WDL, v); chk("R10 wdl held while busy", v, 32'h3333_4444);
    chk("R10 swWdata held", swWdata, 64'h1111_2222_3333_4444);
    hostWr(A_CMD, 32'h0703_0003);
    hostRd(A_CMD, v); chk("R7 cmd ignored while busy", v, 32'h0509_0001);
    @(negedge clk);
    swRdata = 64'hCAFE_F00D_0BAD_1DEA;
    swDone = 1;
    hostWrNow(A_CMD, 32'h0A0B_0001);
    swDone = 0;
    hostRd(A_CMD, v); chk("R5 R7 collision idle, old fields", v, 32'h0509_0000);
    hostRd(A_RDH, v); chk("R6 collision rdh", v, 32'hCAFE_F00D);
    hostRd(A_RDL, v); chk("R6 collision rdl", v, 32'h0BAD_1DEA);
    repeat (4) @(negedge clk);
    chk("R7 no strobe from collision", strobeCount, sc + 1);
    // write completion in manual mode leaves read words
    hostWr(A_CMD, 32'h0102_0003);
    @(negedge clk);
    swRdata = 64'h0;
    swDone = 1;
    @(negedge clk);
    swDone = 0;
    hostRd(A_CMD, v); chk("R5 write done clears go", v, 32'h0102_0002);
    hostRd(A_RDL, v); chk("R6 write done keeps rdl", v, 32'h0BAD_1DEA);

    // R9 bridge reset
    sc = strobeCount;
    hostWr(A_WDH, 32'h9999_0000);
    hostWr(A_CMD, 32'h0405_0005);
    hostRd(A_WDH, v);  chk("R9 wdh cleared", v, 0);
    hostRd(A_WDL, v);  chk("R9 wdl cleared", v, 0);
    hostRd(A_RDH, v);  chk("R9 rdh cleared", v, 0);
    hostRd(A_RDL, v);  chk("R9 rdl cleared", v, 0);
    hostRd(A_CMD, v);  chk("R9 cmd cleared", v, 0);
    hostRd(A_CTRL, v); chk("R9 request and grant kept", v, 32'h58);
    repeat (3) @(negedge clk);
    chk("R9 no launch", strobeCount, sc);

    hostWr(A_CTRL, 32'h0);
    hostRd(A_CTRL, v); chk("R3 final release", v, 32'h40);
    finishRun();
  end
endmodule